// File: doc/BRIEF.md
# BCD Calendar Clock with Holding Registers

This block keeps wall-clock time and calendar date in BCD. A timekeeping core advances once per second, derived from a 32.768 kHz tick enable. It holds seconds, minutes, hours, a day-of-week counter, day of month, month and a two-digit year covering 2000 to 2099. A host never reads or writes the core directly. It sees a bank of holding registers through a simple address/data/write-strobe port, with read data registered one cycle after the address.

Two handshake bits in the control register keep each access coherent. Raising the freeze bit copies the running core into the holding bank in a single cycle. If a one-second step lands on that same cycle, the copy takes the stepped value. The bank then stays frozen until the bit is cleared. Setting the lock bit stops the core and opens the holding bank to host writes. Clearing it loads the whole bank into the core at once and restarts the sub-second prescaler. A calibration bit swaps the calibration output from idle-low to a 512 Hz square wave derived from the tick prescaler.

Register map: address 0 is control, with bit 0 = freeze, bit 1 = lock and bit 2 = calibration. Addresses 1 to 7 hold seconds, minutes, hours, day-of-week, day of month, month and year, each one BCD byte.

Top module: `rtc_calendar`

## Requirements
- R1: The seconds field advances once every TICKS_PER_SEC asserted cycles of `tick_en`. The core steps on the clock edge that samples the last of those ticks, counted from the lock-release edge.
- R2: Every field is BCD. Seconds roll from 59 to 00 and carry into minutes, minutes roll from 59 to 00 and carry into hours, and hours roll from 23 to 00 and carry into the date.
- R3: Day-of-week counts 1 to 7, advances at each midnight rollover and wraps from 7 to 1.
- R4: Day of month wraps to 01 after the month's last day (30 for months 04, 06, 09, 11; 31 for the others except February). Month wraps from 12 to 01 and carries into the year, and year wraps from 99 to 00.
- R5: February has 29 days when the two-digit year is divisible by four (00 included), and 28 otherwise.
- R6: A control write that sets bit 0 while it was 0 copies the core into the holding bank at that write's edge. If the core steps at that same edge, the stepped value is copied.
- R7: While bit 0 stays 1 the holding bank does not change. Once bit 0 and bit 1 are both 0, the bank follows the core again one cycle behind.
- R8: While bit 1 is 1 the core does not advance, and host writes to addresses 1 to 7 are stored in the holding bank. With bit 1 at 0, such writes are ignored.
- R9: A control write that clears bit 1 while it was 1 loads all seven holding bytes into the core at that edge and restarts the one-second prescaler.
- R10: With bit 2 set, `cal_out` toggles once every TICKS_PER_SEC/1024 ticks, giving 512 Hz. With bit 2 clear, `cal_out` is 0 from the next cycle on.
- R11: After reset the control register reads 0 and the time reads 00:00:00, day-of-week 01, date 01, month 01, year 00.
- R12: `host_rdata` shows, one cycle after `host_addr` is presented, the control bits at address 0 (upper bits 0), the holding byte at addresses 1 to 7, and 0 at any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle enable per 32.768 kHz time-base tick |
| host_we | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data for the address of the previous cycle |
| cal_out | output | 1 | 512 Hz square wave in calibration mode, else 0 |

## Verification
The bench sets times just short of midnight on month ends, on leap and non-leap Februaries, and at the year-99 boundary. A wrong month-length or leap rule shows up there as an impossible date such as 30 February or a skipped 29 February. It places the freeze edge exactly on, and one cycle before, the one-second step. A design that ignores a pending step would return the stale second, while one that refreshes during freeze would drift while frozen. It also writes time bytes with the lock bit clear, locks and waits across several second boundaries, and counts calibration toggles against the tick rate, which catches leaking writes, a running core under lock and a wrong divider tap.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int NUM_FIELDS = 7;
  localparam int BYTE_W     = 8;

  // field indices; host address of a field is index + 1
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HR   = 2;
  localparam int F_DOW  = 3;
  localparam int F_DATE = 4;
  localparam int F_MON  = 5;
  localparam int F_YR   = 6;

  // control register bit positions
  localparam int CTRL_FRZ = 0;
  localparam int CTRL_LCK = 1;
  localparam int CTRL_CAL = 2;
  localparam int CTRL_W   = 3;

  typedef logic [NUM_FIELDS-1:0][BYTE_W-1:0] rtc_time_t;

  // year 00, month 01, date 01, dow 01, 00:00:00
  localparam rtc_time_t TIME_RESET = {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // tens*10 mod 4 equals 2 for odd tens, so divisibility by four
  // needs ones == 2 or 6 for odd tens, ones == 0, 4 or 8 for even tens
  function automatic logic is_leap(input logic [7:0] yr);
    if (yr[4]) return yr[1:0] == 2'b10;
    return yr[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
// Divides the tick enable down to a one-second step pulse and exposes the
// prescaler bit that toggles at 512 Hz. TICKS_PER_SEC must be a power of
// two no smaller than 1024.
module rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic restart,
  output logic sec_pulse,
  output logic cal_phase
);

  localparam int CNT_W   = $clog2(TICKS_PER_SEC);
  localparam int CAL_BIT = CNT_W - 10;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICKS_PER_SEC - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (tick_en) begin
      cnt <= (cnt == CNT_LAST) ? '0 : cnt + 1'b1;
    end
  end

  assign sec_pulse = tick_en && (cnt == CNT_LAST) && !restart;
  assign cal_phase = cnt[CAL_BIT];

endmodule

// File: rtl/rtc_core.sv
// Timekeeping core: BCD calendar state with one-second advance and a
// whole-state parallel load.
module rtc_core
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      step,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t cur,
  output rtc_time_t adv
);

  logic sec_wrap, min_wrap, hr_wrap, date_wrap, mon_wrap;

  always_comb begin
    sec_wrap  = (cur[F_SEC] == 8'h59);
    min_wrap  = (cur[F_MIN] == 8'h59);
    hr_wrap   = (cur[F_HR] == 8'h23);
    date_wrap = (cur[F_DATE] == month_last(cur[F_MON], cur[F_YR]));
    mon_wrap  = (cur[F_MON] == 8'h12);
  end

  always_comb begin
    adv = cur;
    adv[F_SEC] = sec_wrap ? 8'h00 : bcd_inc(cur[F_SEC]);
    if (sec_wrap) begin
      adv[F_MIN] = min_wrap ? 8'h00 : bcd_inc(cur[F_MIN]);
      if (min_wrap) begin
        adv[F_HR] = hr_wrap ? 8'h00 : bcd_inc(cur[F_HR]);
        if (hr_wrap) begin
          adv[F_DOW]  = (cur[F_DOW] == 8'h07) ? 8'h01 : bcd_inc(cur[F_DOW]);
          adv[F_DATE] = date_wrap ? 8'h01 : bcd_inc(cur[F_DATE]);
          if (date_wrap) begin
            adv[F_MON] = mon_wrap ? 8'h01 : bcd_inc(cur[F_MON]);
            if (mon_wrap) begin
              adv[F_YR] = (cur[F_YR] == 8'h99) ? 8'h00 : bcd_inc(cur[F_YR]);
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= TIME_RESET;
    end else if (load) begin
      cur <= load_val;
    end else if (step) begin
      cur <= adv;
    end
  end

endmodule

// File: rtl/rtc_host_regs.sv
// Host-visible control register and holding bank with freeze and lock
// handshakes, plus the registered read mux.
module rtc_host_regs
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  input  rtc_time_t         core_cur,
  input  rtc_time_t         core_adv,
  input  logic              core_step,
  output rtc_time_t         hold,
  output logic              rd_frz,
  output logic              wr_lck,
  output logic              cal_en,
  output logic              commit,
  output logic [7:0]        host_rdata
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;

  logic      ctrl_we;
  logic      snapshot;
  logic      frozen;
  rtc_time_t snap_src;
  logic [7:0] rd_mux;

  assign ctrl_we  = host_we && (host_addr == CTRL_ADDR);
  assign snapshot = ctrl_we && host_wdata[CTRL_FRZ] && !rd_frz;
  assign commit   = ctrl_we && !host_wdata[CTRL_LCK] && wr_lck;
  assign frozen   = rd_frz || wr_lck;
  assign snap_src = core_step ? core_adv : core_cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_frz <= 1'b0;
      wr_lck <= 1'b0;
      cal_en <= 1'b0;
    end else if (ctrl_we) begin
      rd_frz <= host_wdata[CTRL_FRZ];
      wr_lck <= host_wdata[CTRL_LCK];
      cal_en <= host_wdata[CTRL_CAL];
    end
  end

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    localparam logic [ADDR_W-1:0] FIELD_ADDR = ADDR_W'(i + 1);
    logic field_we;
    assign field_we = host_we && (host_addr == FIELD_ADDR) && wr_lck;

    always_ff @(posedge clk) begin
      if (rst) begin
        hold[i] <= TIME_RESET[i];
      end else if (snapshot) begin
        hold[i] <= snap_src[i];
      end else if (field_we) begin
        hold[i] <= host_wdata;
      end else if (!frozen) begin
        hold[i] <= core_cur[i];
      end
    end
  end

  always_comb begin
    rd_mux = 8'h00;
    if (host_addr == CTRL_ADDR) begin
      rd_mux = {5'b00000, cal_en, wr_lck, rd_frz};
    end
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (host_addr == ADDR_W'(i + 1)) rd_mux = hold[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= 8'h00;
    else     host_rdata <= rd_mux;
  end

endmodule

// File: rtl/rtc_calendar.sv
// Top level: prescaler, timekeeping core, host register bank and the
// registered calibration output.
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int ADDR_W        = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              cal_out
);

  logic      sec_pulse;
  logic      cal_phase;
  logic      core_step;
  logic      commit;
  logic      rd_frz;
  logic      wr_lck;
  logic      cal_en;
  rtc_time_t core_time;
  rtc_time_t core_adv;
  rtc_time_t hold_time;

  assign core_step = sec_pulse && !wr_lck;

  rtc_prescaler #(
    .TICKS_PER_SEC(TICKS_PER_SEC)
  ) u_presc (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .restart  (commit),
    .sec_pulse(sec_pulse),
    .cal_phase(cal_phase)
  );

  rtc_core u_core (
    .clk     (clk),
    .rst     (rst),
    .step    (core_step),
    .load    (commit),
    .load_val(hold_time),
    .cur     (core_time),
    .adv     (core_adv)
  );

  rtc_host_regs #(
    .ADDR_W(ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .host_we   (host_we),
    .host_addr (host_addr),
    .host_wdata(host_wdata),
    .core_cur  (core_time),
    .core_adv  (core_adv),
    .core_step (core_step),
    .hold      (hold_time),
    .rd_frz    (rd_frz),
    .wr_lck    (wr_lck),
    .cal_en    (cal_en),
    .commit    (commit),
    .host_rdata(host_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) cal_out <= 1'b0;
    else     cal_out <= cal_en && cal_phase;
  end

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
  import rtc_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input rtc_time_t core_time,
  input rtc_time_t hold,
  input logic      rd_frz,
  input logic      wr_lck,
  input logic      cal_en,
  input logic      cal_out,
  input logic      sec_pulse,
  input logic      commit
);

  AST_SEC_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(core_time) |-> $past(sec_pulse || commit)); // R1

  AST_SEC_BCD: assert property (@(posedge clk) disable iff (rst)
    core_time[F_SEC][3:0] <= 4'd9 && core_time[F_SEC][7:4] <= 4'd5); // R2

  AST_DOW_RANGE: assert property (@(posedge clk) disable iff (rst)
    core_time[F_DOW] >= 8'h01 && core_time[F_DOW] <= 8'h07); // R3

  AST_DATE_LIMIT: assert property (@(posedge clk) disable iff (rst)
    core_time[F_DATE] <= month_last(core_time[F_MON], core_time[F_YR])); // R4

  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (rd_frz && !wr_lck) && $past(rd_frz && !wr_lck) |-> $stable(hold)); // R7

  AST_CORE_PAUSED: assert property (@(posedge clk) disable iff (rst)
    wr_lck && $past(wr_lck) |-> $stable(core_time)); // R8

  AST_COMMIT_LOAD: assert property (@(posedge clk) disable iff (rst)
    commit |=> core_time == $past(hold)); // R9

  AST_CAL_OFF: assert property (@(posedge clk) disable iff (rst)
    $past(!cal_en) |-> !cal_out); // R10

endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .core_time(core_time),
  .hold     (hold_time),
  .rd_frz   (rd_frz),
  .wr_lck   (wr_lck),
  .cal_en   (cal_en),
  .cal_out  (cal_out),
  .sec_pulse(sec_pulse),
  .commit   (commit)
);

// File: tb/rtc_calendar_test.sv
module rtc_calendar_test;

  localparam int TPS = 1024;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic       host_we = 1'b0;
  logic [3:0] host_addr = 4'd0;
  logic [7:0] host_wdata = 8'd0;
  logic [7:0] host_rdata;
  logic       cal_out;

  int tick_mode = 0;
  int tc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int e [7];

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tc <= tc + 1;
    tick_en <= (tick_mode == 1) || (tick_mode == 4 && (tc % 4) == 0);
  end

  rtc_calendar #(.TICKS_PER_SEC(TPS), .ADDR_W(4)) uut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .cal_out(cal_out)
  );

  function automatic int days_in(int m, int y);
    case (m)
      2: return (y % 4 == 0) ? 29 : 28;
      4, 6, 9, 11: return 30;
      default: return 31;
    endcase
  endfunction

  function automatic logic [7:0] bcd(int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function void step_model();
    e[0]++; if (e[0] < 60) return;
    e[0] = 0; e[1]++; if (e[1] < 60) return;
    e[1] = 0; e[2]++; if (e[2] < 24) return;
    e[2] = 0; e[3] = (e[3] == 7) ? 1 : e[3] + 1;
    e[4]++; if (e[4] <= days_in(e[5], e[6])) return;
    e[4] = 1; e[5]++; if (e[5] <= 12) return;
    e[5] = 1; e[6] = (e[6] + 1) % 100;
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input int a, input int d);
    host_we = 1'b1; host_addr = 4'(a); host_wdata = 8'(d);
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    host_addr = 4'(a);
    @(negedge clk);
    v = int'(host_rdata);
  endtask

  task automatic set_time(input int s, input int m, input int h, input int dw,
                          input int d, input int mo, input int y);
    e[0] = s; e[1] = m; e[2] = h; e[3] = dw; e[4] = d; e[5] = mo; e[6] = y;
    wr(0, 2);
    for (int i = 0; i < 7; i++) wr(i + 1, int'(bcd(e[i])));
    wr(0, 0);
  endtask

  task automatic check_all(input string tag);
    int v;
    wr(0, 1);
    for (int i = 0; i < 7; i++) begin
      rd(i + 1, v);
      chk(tag, v, int'(bcd(e[i])));
    end
    wr(0, 0);
  endtask

  task automatic roll_case(input string tag, input int s, input int m, input int h,
                           input int dw, input int d, input int mo, input int y);
    set_time(s, m, h, dw, d, mo, y);
    repeat (1030) @(negedge clk);
    step_model();
    check_all(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1 got=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int v;
    int n;
    int bad;
    logic prev;
    void'($urandom(32'd20513));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    rd(0, v); chk("R11 ctrl", v, 0);
    e[0] = 0; e[1] = 0; e[2] = 0; e[3] = 1; e[4] = 1; e[5] = 1; e[6] = 0;
    for (int i = 0; i < 7; i++) begin
      rd(i + 1, v); chk("R11 field", v, int'(bcd(e[i])));
    end

    // R12 unmapped addresses and control readback
    rd(10, v); chk("R12 addr 10", v, 0);
    rd(15, v); chk("R12 addr 15", v, 0);
    wr(0, 4); rd(0, v); chk("R12 ctrl readback", v, 4);
    wr(0, 0);

    // R1 step timing after commit; R9 prescaler restart
    tick_mode = 1;
    set_time(30, 20, 10, 3, 15, 6, 24);
    host_addr = 4'd1;
    repeat (1025) @(negedge clk);
    chk("R1 before step", int'(host_rdata), 8'h30);
    @(negedge clk);
    chk("R1 after step", int'(host_rdata), 8'h31);

    // R6 freeze exactly on the step edge takes the stepped value
    set_time(58, 59, 0, 2, 10, 3, 23);
    repeat (1023) @(negedge clk);
    wr(0, 1);
    rd(1, v); chk("R6 pending sec", v, 8'h59);
    rd(2, v); chk("R6 pending min", v, 8'h59);
    // R7 frozen across a core step
    repeat (1100) @(negedge clk);
    rd(1, v); chk("R7 frozen sec", v, 8'h59);
    rd(2, v); chk("R7 frozen min", v, 8'h59);
    wr(0, 0);
    repeat (3) @(negedge clk);
    rd(1, v); chk("R7 refresh sec", v, 8'h00);
    rd(2, v); chk("R7 refresh min", v, 8'h00);
    rd(3, v); chk("R7 refresh hr", v, 8'h01);

    // R6 freeze one cycle before the step keeps old value
    set_time(58, 0, 0, 2, 10, 3, 23);
    repeat (1022) @(negedge clk);
    wr(0, 1);
    rd(1, v); chk("R6 early sec", v, 8'h58);
    wr(0, 0);

    // R8 writes without lock are ignored
    set_time(5, 7, 9, 4, 20, 8, 30);
    wr(1, 8'h44);
    repeat (3) @(negedge clk);
    rd(1, v); chk("R8 unlocked write", v, 8'h05);
    wr(0, 1);
    wr(1, 8'h44);
    rd(1, v); chk("R8 frozen write", v, 8'h05);
    wr(0, 0);
    // R8 lock accepts writes and holds across second boundaries
    wr(0, 2);
    wr(2, 8'h33);
    repeat (2100) @(negedge clk);
    rd(2, v); chk("R8 locked min", v, 8'h33);
    rd(1, v); chk("R8 locked sec", v, 8'h05);
    // R9 release loads the bank, core did not run while locked
    wr(0, 0);
    e[0] = 5; e[1] = 33; e[2] = 9; e[3] = 4; e[4] = 20; e[5] = 8; e[6] = 30;
    check_all("R9 commit");

    // directed calendar corners
    roll_case("R5 leap 28 feb", 59, 59, 23, 7, 28, 2, 24);
    roll_case("R5 leap 29 feb", 59, 59, 23, 3, 29, 2, 24);
    roll_case("R5 plain 28 feb", 59, 59, 23, 3, 28, 2, 23);
    roll_case("R5 year 00 feb", 59, 59, 23, 1, 28, 2, 0);
    roll_case("R4 year wrap", 59, 59, 23, 5, 31, 12, 99);
    roll_case("R4 30 day month", 59, 59, 23, 6, 30, 4, 50);
    roll_case("R3 dow wrap", 59, 59, 23, 7, 12, 5, 61);
    roll_case("R2 hour carry", 59, 59, 22, 7, 31, 1, 0);

    // random carries
    for (int it = 0; it < 16; it++) begin
      int mo, y, d, h, m, dw;
      mo = 1 + int'($urandom % 12);
      y  = int'($urandom % 100);
      d  = ($urandom % 2 == 1) ? days_in(mo, y) : 1 + int'($urandom % days_in(mo, y));
      h  = ($urandom % 3 == 0) ? 23 : int'($urandom % 24);
      m  = ($urandom % 2 == 1) ? 59 : int'($urandom % 60);
      dw = 1 + int'($urandom % 7);
      roll_case("R2 R4 random carry", 59, m, h, dw, d, mo, y);
    end

    // R10 calibration output
    wr(0, 4);
    tick_mode = 4;
    repeat (8) @(negedge clk);
    prev = cal_out;
    n = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (cal_out != prev) n++;
      prev = cal_out;
    end
    chk("R10 toggles per tick", (n >= 99 && n <= 101) ? 100 : n, 100);
    wr(0, 0);
    repeat (2) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (cal_out) bad++;
    end
    chk("R10 idle low", bad, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule